// File: doc/BRIEF.md
# Counting Response Compactor

This block reduces the single-bit response stream of a circuit under test to one count. A test begins with a start strobe that clears the counters and latches the compaction mode. Each applied pattern is marked by a valid strobe carrying one response bit. A done strobe closes the test and compares the count with a fault-free reference value that was computed offline.

Three compaction modes are offered. Ones mode counts the response bits that are 1. Transition mode counts every change of the response bit between consecutive accepted patterns, rising or falling, using a register that holds the previous bit. Syndrome mode counts ones under random stimulus, and the pattern counter next to it gives the denominator of the ones ratio. Both counters have the same parameterised width, so they can hold the full test length.

Top module: `resp_compactor`

## Requirements
- R1: After reset, `count_o`, `patterns_o`, `result_valid_o` and `pass_o` are all 0 and no test is active.
- R2: A `start_i` pulse clears `count_o` and `patterns_o` and `result_valid_o` at the next edge, latches `mode_i` for the whole test and makes the test active. A `valid_i` in the start cycle is not counted.
- R3: While a test is active, each `valid_i` cycle without `start_i` or `done_i` is accepted, and `patterns_o` rises by one at the following edge.
- R4: With mode code 0 (ones), or code 3, which behaves the same way, `count_o` rises by one for each accepted bit equal to 1.
- R5: With mode code 1 (transitions), `count_o` rises by one for each accepted bit that differs from the previously accepted bit, in either direction. The first accepted bit after start is never counted and only loads the previous-bit register.
- R6: With mode code 2 (syndrome), `count_o` holds the number of accepted 1s and `patterns_o` holds the number of accepted patterns. An all-zero stream gives 0 and an all-one stream of m bits gives m.
- R7: `done_i` during an active test ends it. From the next edge `result_valid_o` is 1 until the next start, and `pass_o` is 1 exactly when `count_o` equals `ref_i` as sampled in the done cycle. A `valid_i` in the done cycle is not counted.
- R8: `valid_i` while no test is active leaves `count_o` and `patterns_o` unchanged.
- R9: `count_o` never exceeds `patterns_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begins a test: clears the counters and latches the mode |
| valid_i | input | 1 | One applied pattern; its response is on `resp_i` |
| resp_i | input | 1 | Response bit from the circuit under test |
| mode_i | input | 2 | 0 ones, 1 transitions, 2 syndrome, 3 ones |
| ref_i | input | W | Fault-free reference count, sampled at done |
| done_i | input | 1 | Ends the test and latches the verdict |
| count_o | output | W | Compacted count |
| patterns_o | output | W | Number of accepted patterns |
| result_valid_o | output | 1 | Verdict is valid |
| pass_o | output | 1 | Count matched the reference |

## Verification
Random streams in every mode are compared with counts computed by the bench. These show that ones and transitions are counted by different rules on the same kind of input. An all-zero and an all-one stream give the extreme counts, and in transition mode both give zero, so a mode mix-up or a counter stuck at the pattern count shows up. An alternating stream and a lone 1 as the first bit check the transition direction and the first-bit exemption. A wrong reference, strobes arriving outside a test, and a valid in the start or done cycle check the verdict and the acceptance window.

// File: rtl/resp_cmp_pkg.sv
package resp_cmp_pkg;

  typedef enum logic [1:0] {
    CMP_ONES     = 2'd0,
    CMP_TRANS    = 2'd1,
    CMP_SYND     = 2'd2,
    CMP_ONES_ALT = 2'd3
  } cmp_mode_e;

  // Does one accepted response bit add to the count?
  function automatic logic count_hit(cmp_mode_e mode, logic bit_i,
                                     logic prev, logic first);
    logic hit;
    case (mode)
      CMP_TRANS: hit = !first && (bit_i != prev);
      default:   hit = bit_i;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/rc_counter.sv
module rc_counter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= q + ONE;
  end
endmodule

// File: rtl/rc_track.sv
module rc_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic accept,
  input  logic resp,
  output logic prev_q,
  output logic first_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      first_q <= 1'b1;
    end else if (start) begin
      first_q <= 1'b1;
    end else if (accept) begin
      prev_q  <= resp;
      first_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rc_verdict.sv
module rc_verdict #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         finish,
  input  logic [W-1:0] count,
  input  logic [W-1:0] ref_val,
  output logic         result_valid,
  output logic         pass
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_valid <= 1'b0;
      pass         <= 1'b0;
    end else if (start) begin
      result_valid <= 1'b0;
      pass         <= 1'b0;
    end else if (finish) begin
      result_valid <= 1'b1;
      pass         <= (count == ref_val);
    end
  end
endmodule

// File: rtl/resp_compactor.sv
module resp_compactor
  import resp_cmp_pkg::*;
#(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         valid_i,
  input  logic         resp_i,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] ref_i,
  input  logic         done_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] patterns_o,
  output logic         result_valid_o,
  output logic         pass_o
);
  logic      active_q;
  cmp_mode_e mode_q;
  logic      accept;
  logic      done_eff;
  logic      hit;
  logic      prev_q;
  logic      first_q;

  assign accept   = active_q && valid_i && !start_i && !done_i;
  assign done_eff = active_q && done_i && !start_i;
  assign hit      = accept && count_hit(mode_q, resp_i, prev_q, first_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      mode_q   <= CMP_ONES;
    end else if (start_i) begin
      active_q <= 1'b1;
      mode_q   <= cmp_mode_e'(mode_i);
    end else if (done_eff) begin
      active_q <= 1'b0;
    end
  end

  rc_track u_track (
    .clk(clk), .rst_n(rst_n), .start(start_i), .accept(accept),
    .resp(resp_i), .prev_q(prev_q), .first_q(first_q)
  );

  rc_counter #(.W(W)) u_cnt_event (
    .clk(clk), .rst_n(rst_n), .clr(start_i), .inc(hit), .q(count_o)
  );

  rc_counter #(.W(W)) u_cnt_pat (
    .clk(clk), .rst_n(rst_n), .clr(start_i), .inc(accept), .q(patterns_o)
  );

  rc_verdict #(.W(W)) u_verdict (
    .clk(clk), .rst_n(rst_n), .start(start_i), .finish(done_eff),
    .count(count_o), .ref_val(ref_i),
    .result_valid(result_valid_o), .pass(pass_o)
  );
endmodule

// File: rtl/rc_checker.sv
module rc_checker
  import resp_cmp_pkg::*;
#(
  parameter int W = 20
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic [W-1:0] ref_i,
  input logic [W-1:0] count_o,
  input logic [W-1:0] patterns_o,
  input logic         result_valid_o,
  input logic         pass_o,
  input logic         active_q,
  input cmp_mode_e    mode_q,
  input logic         accept,
  input logic         first_q,
  input logic         done_eff
);
  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (count_o == '0 && patterns_o == '0 && !result_valid_o));

  // R3
  pattern_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> patterns_o == W'($past(patterns_o) + W'(1)));

  // R5
  first_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && first_q && mode_q == CMP_TRANS) |=> $stable(count_o));

  // R7
  verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_eff |=> (result_valid_o && pass_o == ($past(count_o) == $past(ref_i))));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !start_i) |=> ($stable(count_o) && $stable(patterns_o)));

  // R9
  no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= patterns_o);
endmodule

bind resp_compactor rc_checker #(.W(W)) u_rc_checker (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .ref_i(ref_i),
  .count_o(count_o), .patterns_o(patterns_o),
  .result_valid_o(result_valid_o), .pass_o(pass_o),
  .active_q(active_q), .mode_q(mode_q), .accept(accept),
  .first_q(first_q), .done_eff(done_eff)
);

// File: tb/test_resp_compactor.sv
`timescale 1ns/1ps
module test_resp_compactor;
  localparam int W = 20;
  localparam int MAXN = 512;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0, valid_i = 1'b0, resp_i = 1'b0, done_i = 1'b0;
  logic [1:0]   mode_i = 2'd0;
  logic [W-1:0] ref_i = '0;
  logic [W-1:0] count_o, patterns_o;
  logic         result_valid_o, pass_o;

  int n_tests = 0;
  int n_fail = 0;
  logic [MAXN-1:0] bits;

  always #2.5 clk = ~clk;

  resp_compactor #(.W(W)) i_resp_compactor (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
    .resp_i(resp_i), .mode_i(mode_i), .ref_i(ref_i), .done_i(done_i),
    .count_o(count_o), .patterns_o(patterns_o),
    .result_valid_o(result_valid_o), .pass_o(pass_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic begin_test(input logic [1:0] m);
    mode_i = m; start_i = 1'b1; tick(); start_i = 1'b0; mode_i = 2'd0;
  endtask

  task automatic feed(input logic b);
    valid_i = 1'b1; resp_i = b; tick(); valid_i = 1'b0; resp_i = 1'b0;
  endtask

  task automatic end_test(input logic [W-1:0] r);
    ref_i = r; done_i = 1'b1; tick(); done_i = 1'b0; ref_i = '0;
  endtask

  // Expected count, restated from the mode rules
  function automatic int model(input logic [1:0] m, input int n);
    int c = 0;
    for (int i = 0; i < n; i++) begin
      if (m == 2'd1) begin
        if (i > 0 && bits[i] !== bits[i-1]) c++;
      end else if (bits[i]) c++;
    end
    return c;
  endfunction

  task automatic run_stream(input string req, input logic [1:0] m, input int n);
    int exp = model(m, n);
    begin_test(m);
    for (int i = 0; i < n; i++) feed(bits[i]);
    check(req, "count", count_o, exp);
    check("R3", "patterns", patterns_o, n);
    end_test(W'(exp));
    check("R7", "result_valid", result_valid_o, 1);
    check("R7", "pass on match", pass_o, 1);
  endtask

  task automatic t_reset();
    check("R1", "count", count_o, 0);
    check("R1", "patterns", patterns_o, 0);
    check("R1", "result_valid", result_valid_o, 0);
    check("R1", "pass", pass_o, 0);
  endtask

  task automatic t_random_modes();
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 200; i++) bits[i] = 1'($urandom);
      case (k)
        0: run_stream("R4", 2'd0, 200);
        1: run_stream("R5", 2'd1, 200);
        2: run_stream("R6", 2'd2, 200);
        default: run_stream("R4", 2'd3, 200);
      endcase
    end
  endtask

  task automatic t_extremes();
    bits = '0;
    run_stream("R6", 2'd2, 64);
    check("R6", "all zero count", count_o, 0);
    bits = '1;
    run_stream("R6", 2'd2, 64);
    check("R6", "all one count m", count_o, 64);
    run_stream("R5", 2'd1, 64);
    check("R5", "all one transitions", count_o, 0);
    for (int i = 0; i < 50; i++) bits[i] = 1'(i % 2);
    run_stream("R5", 2'd1, 50);
    check("R5", "alternating transitions", count_o, 49);
  endtask

  task automatic t_first_bit();
    begin_test(2'd1);
    feed(1'b1);
    check("R5", "first bit counts nothing", count_o, 0);
    feed(1'b0);
    check("R5", "falling edge counted", count_o, 1);
    end_test(W'(1));
  endtask

  task automatic t_mismatch();
    begin_test(2'd0);
    feed(1'b1); feed(1'b1); feed(1'b0);
    end_test(W'(3));
    check("R7", "pass on mismatch", pass_o, 0);
    check("R7", "result_valid on mismatch", result_valid_o, 1);
  endtask

  task automatic t_window();
    // inactive after previous done: valid ignored
    feed(1'b1); feed(1'b1);
    check("R8", "idle count", count_o, 2);
    check("R8", "idle patterns", patterns_o, 3);
    // valid in the start cycle is ignored
    mode_i = 2'd0; start_i = 1'b1; valid_i = 1'b1; resp_i = 1'b1; tick();
    start_i = 1'b0; valid_i = 1'b0; resp_i = 1'b0;
    check("R2", "start cycle valid ignored", patterns_o, 0);
    check("R2", "result_valid cleared", result_valid_o, 0);
    feed(1'b1);
    // valid in the done cycle is ignored
    ref_i = W'(1); done_i = 1'b1; valid_i = 1'b1; resp_i = 1'b1; tick();
    done_i = 1'b0; valid_i = 1'b0; resp_i = 1'b0;
    check("R7", "done cycle valid ignored", count_o, 1);
    check("R7", "pass with ref sampled at done", pass_o, 1);
    check("R9", "count within patterns", longint'(count_o <= patterns_o), 1);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_random_modes();
    t_extremes();
    t_first_bit();
    t_mismatch();
    t_window();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule